// File: doc/BRIEF.md
# Dual-Channel First-Order Sigma-Delta Tally

This block is the digital half of a two-channel first-order sigma-delta converter. Each channel takes a 1-bit comparator level from outside the chip, passes it through a two-stage synchronizer, and samples it on every cycle where the tick enable is high. On each tick the channel drives the complement of the sampled bit onto its feedback output. An external RC network closes the loop with that output, so over time the fraction of high samples follows the analog input level.

A per-channel counter tallies the ticks on which the sample was high. A per-channel window counter advances on every tick and wraps once every 256 ticks. On the wrapping tick the tally, including that tick's own sample, is copied into the channel's result register, and the tally starts again from zero. The result is a plain count of high samples over a fixed window. There is no decimation filter. The result registers are read directly from the port and reading them has no side effects.

The widths, the number of channels and the synchronizer depth are parameters. The defaults are two channels, 8-bit counters and two synchronizer stages.

Top module: `dual_sd_tally`

## Requirements
- R1: While reset is asserted, and right after it, every result is 0 and every feedback output is 0. Reset also clears the tally and window counters, so the first window after reset spans exactly 256 ticks.
- R2: After each tick, `fb_out[c]` equals the inverse of the sample taken at that tick. The sample is the level that `cmp_in[c]` held at the two clock edges before the tick edge (two-stage synchronizer).
- R3: The tally of a channel grows by one on each tick whose sample is 1, and stays the same on each tick whose sample is 0.
- R4: On every 256th tick after reset, the channel's result is loaded with the number of 1 samples in the last 256 ticks, modulo 256. This count includes the sample of the wrapping tick itself. The next window then counts from zero.
- R5: A window in which all 256 samples are 1 yields a result of 0 (8-bit wrap). A window with 255 ones yields 255.
- R6: A result register changes only on a window-ending tick. Between such ticks it holds its value however often it is read.
- R7: On cycles with `tick` low, no tally, window counter, result or feedback output changes, whatever the comparator inputs do.
- R8: The channels are independent. Channel c uses `cmp_in[c]` and `fb_out[c]`, and its result sits in `result_bus[c*8 +: 8]`.
- R9: Closed around a behavioural RC integrator with a mid-rail comparator, a constant input at fraction f of full scale gives results within ±2 of round(256·f) once the loop has settled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Sample enable: one conversion step per high cycle |
| cmp_in | input | 2 | Comparator levels, one bit per channel |
| fb_out | output | 2 | Feedback drive, inverse of the last sample, one bit per channel |
| result_bus | output | 16 | Conversion results, channel c in bits [c*8 +: 8] |

## Verification
The bench targets four corner cases, and each one exposes a specific kind of wrong design:
- A window with all 256 samples high. A design that saturates instead of wrapping would report 255.
- A window whose only high sample falls on the wrapping tick. A design that latches the tally before adding that tick's bit would report 0 instead of 1.
- The comparator inputs toggle while tick is low, in the middle of a window. A design that samples without the enable would miscount.
- Reset arrives in the middle of a window. A design that fails to clear the tally would carry its partial count into the next result.

Two more checks close the set. The feedback bit is compared against the inverse of every sample. A closed-loop run with an RC model checks that two different input levels are tracked on the two channels at the same time.

// File: rtl/sd_tally_pkg.sv
package sd_tally_pkg;
   localparam int unsigned SDT_CH_DEF   = 2;
   localparam int unsigned SDT_CNT_DEF  = 8;
   localparam int unsigned SDT_SYNC_DEF = 2;
endpackage

// File: rtl/sd_sync.sv
module sd_sync #(
   parameter int unsigned STAGES = sd_tally_pkg::SDT_SYNC_DEF
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);
   if (STAGES < 1) begin : g_bad_depth
      $error("sd_sync: STAGES must be at least 1");
   end

   if (STAGES == 1) begin : g_single
      logic q_r;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) q_r <= 1'b0;
         else        q_r <= d;
      end
      assign q = q_r;
   end else begin : g_chain
      logic [STAGES-1:0] chain_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) chain_q <= '0;
         else        chain_q <= {chain_q[STAGES-2:0], d};
      end
      assign q = chain_q[STAGES-1];

      AST_SYNC_SHIFT: assert property (@(posedge clk) disable iff (!rst_n)
         1'b1 |=> chain_q[0] == $past(d)) else $error("sync first stage");   // R2
   end
endmodule

// File: rtl/sd_window.sv
module sd_window #(
   parameter int unsigned W = sd_tally_pkg::SDT_CNT_DEF
) (
   input  logic clk,
   input  logic rst_n,
   input  logic en,
   output logic at_end
);
   localparam logic [W-1:0] ONE  = {{(W-1){1'b0}}, 1'b1};
   localparam logic [W-1:0] LAST = {W{1'b1}};

   logic [W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  cnt_q <= '0;
      else if (en) cnt_q <= cnt_q + ONE;
   end

   assign at_end = (cnt_q == LAST);

   AST_WIN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      !en |=> $stable(cnt_q)) else $error("window moved without tick");   // R7
   AST_WIN_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      en |=> cnt_q == $past(cnt_q) + ONE) else $error("window step");     // R4
endmodule

// File: rtl/sd_channel.sv
module sd_channel #(
   parameter int unsigned W = sd_tally_pkg::SDT_CNT_DEF
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         tick,
   input  logic         sample,
   output logic         fb,
   output logic [W-1:0] result
);
   logic [W-1:0] tally_q;
   logic [W-1:0] tally_inc;
   logic         win_end;

   sd_window #(.W(W)) u_win (
      .clk    (clk),
      .rst_n  (rst_n),
      .en     (tick),
      .at_end (win_end)
   );

   assign tally_inc = tally_q + {{(W-1){1'b0}}, sample};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tally_q <= '0;
         result  <= '0;
         fb      <= 1'b0;
      end else if (tick) begin
         fb <= ~sample;
         if (win_end) begin
            result  <= tally_inc;
            tally_q <= '0;
         end else begin
            tally_q <= tally_inc;
         end
      end
   end

   AST_FB_INVERT: assert property (@(posedge clk) disable iff (!rst_n)
      tick |=> fb == ~$past(sample)) else $error("feedback polarity");     // R2
   AST_TALLY_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && !win_end) |=> tally_q == $past(tally_q) + {{(W-1){1'b0}}, $past(sample)})
      else $error("tally step");                                          // R3
   AST_TALLY_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && win_end) |=> tally_q == '0) else $error("tally clear");   // R4
   AST_RESULT_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && win_end) |=> result == $past(tally_q) + {{(W-1){1'b0}}, $past(sample)})
      else $error("result load");                                         // R4
   AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !(tick && win_end) |=> $stable(result)) else $error("result moved"); // R6
   AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !tick |=> ($stable(tally_q) && $stable(fb))) else $error("idle change"); // R7
endmodule

// File: rtl/dual_sd_tally.sv
module dual_sd_tally #(
   parameter int unsigned NUM_CH      = sd_tally_pkg::SDT_CH_DEF,
   parameter int unsigned CNT_W       = sd_tally_pkg::SDT_CNT_DEF,
   parameter int unsigned SYNC_STAGES = sd_tally_pkg::SDT_SYNC_DEF
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      tick,
   input  logic [NUM_CH-1:0]         cmp_in,
   output logic [NUM_CH-1:0]         fb_out,
   output logic [NUM_CH*CNT_W-1:0]   result_bus
);
   localparam int unsigned BUS_W = NUM_CH * CNT_W;

   if (NUM_CH < 1) begin : g_bad_ch
      $error("dual_sd_tally: NUM_CH must be at least 1");
   end
   if (CNT_W < 2 || CNT_W > 16) begin : g_bad_w
      $error("dual_sd_tally: CNT_W must lie in 2..16");
   end
   if (BUS_W != $bits(result_bus)) begin : g_bad_bus
      $error("dual_sd_tally: result bus width mismatch");
   end

   for (genvar c = 0; c < NUM_CH; c++) begin : g_ch   // R8
      logic smp;

      sd_sync #(.STAGES(SYNC_STAGES)) u_sync (
         .clk   (clk),
         .rst_n (rst_n),
         .d     (cmp_in[c]),
         .q     (smp)
      );

      sd_channel #(.W(CNT_W)) u_chan (
         .clk    (clk),
         .rst_n  (rst_n),
         .tick   (tick),
         .sample (smp),
         .fb     (fb_out[c]),
         .result (result_bus[c*CNT_W +: CNT_W])
      );
   end

   AST_RESET_CLEAR: assert property (@(posedge clk)
      !rst_n |=> (result_bus == '0 && fb_out == '0)) else $error("reset state"); // R1
endmodule

// File: tb/dual_sd_tally_tb.sv
`timescale 1ns/1ps
module dual_sd_tally_tb;
   localparam int NCH = 2;
   localparam int CW  = 8;
   localparam int WIN = 256;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              tick = 1'b0;
   logic [NCH-1:0]    cmp_in = '0;
   logic [NCH-1:0]    fb_out;
   logic [NCH*CW-1:0] result_bus;

   int n_cmp = 0;
   int n_bad = 0;
   bit done = 0;

   logic [CW-1:0] exp_q[$];
   string         tag_q[$];
   logic [CW-1:0] last_exp [NCH];

   dual_sd_tally u_dut (
      .clk        (clk),
      .rst_n      (rst_n),
      .tick       (tick),
      .cmp_in     (cmp_in),
      .fb_out     (fb_out),
      .result_bus (result_bus)
   );

   always #2.5 clk = ~clk;

   function automatic logic [CW-1:0] res(int ch);
      return result_bus[ch*CW +: CW];
   endfunction

   task automatic check(string req, int act, int exp);
      n_cmp++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   function automatic bit pat(int kind, int ch, int i);
      case (kind)
         0: return (ch == 0) ? 1'b0 : 1'b1;                         // R5 wrap on ch1
         1: return (ch == 0) ? (i < 255) : (i % 2 == 0);            // R5 255 / 128
         2: return (ch == 0) ? (((i * 37 + 11) % 7) < 3) : (i % 3 == 0);
         3: return (ch == 0) ? (i == 255) : (i == 0);               // R4 last tick counted
         default: return (ch == 0) ? (i >= 10) : (i < 200);
      endcase
   endfunction

   // one tick: inputs set at negedge, two edges to synchronize, then tick
   task automatic do_tick(logic [NCH-1:0] bits, bit noise);
      if (noise) begin
         cmp_in = ~bits;
         repeat (2) @(negedge clk);
      end
      cmp_in = bits;
      repeat (2) @(negedge clk);
      tick = 1'b1;
      @(negedge clk);
      tick = 1'b0;
   endtask

   task automatic drive_window(int kind, bit noise, bit idle_mid, string tag);
      int ones [NCH];
      for (int ch = 0; ch < NCH; ch++) ones[ch] = 0;
      for (int i = 0; i < WIN; i++) begin
         logic [NCH-1:0] bits;
         for (int ch = 0; ch < NCH; ch++) begin
            bits[ch] = pat(kind, ch, i);
            ones[ch] += bits[ch];
         end
         if (i == WIN - 1) begin
            for (int ch = 0; ch < NCH; ch++) begin
               exp_q.push_back(CW'(ones[ch]));
               tag_q.push_back(tag);
               last_exp[ch] = CW'(ones[ch]);
            end
         end
         do_tick(bits, noise);
         for (int ch = 0; ch < NCH; ch++)
            check("R2 fb inverse of sample", fb_out[ch], !bits[ch]);
         if (i == 128) begin
            for (int ch = 0; ch < NCH; ch++)
               check("R6 result held mid-window", res(ch), last_exp[ch]);
         end
         if (idle_mid && i == 100) begin
            logic [NCH-1:0] fb_keep;
            fb_keep = fb_out;
            for (int k = 0; k < 40; k++) begin
               cmp_in = NCH'(k);
               @(negedge clk);
            end
            check("R7 fb unchanged while idle", fb_out, fb_keep);
            for (int ch = 0; ch < NCH; ch++)
               check("R7 result unchanged while idle", res(ch), last_exp[ch]);
         end
      end
   endtask

   // monitor: counts ticks, pops expected results after each window end
   initial begin
      int cnt = 0;
      forever begin
         @(posedge clk);
         if (!rst_n) cnt = 0;
         else if (tick) begin
            cnt++;
            if (cnt % WIN == 0) begin
               @(negedge clk);
               for (int ch = 0; ch < NCH; ch++) begin
                  if (exp_q.size() != 0) begin
                     logic [CW-1:0] e;
                     string t;
                     e = exp_q.pop_front();
                     t = tag_q.pop_front();
                     check($sformatf("%s ch%0d", t, ch), res(ch), e);
                  end
               end
            end
         end
      end
   end

   task automatic rc_run(real vin0, real vin1, int nwin, int check_from);
      real v [NCH];
      real vin [NCH];
      real a;
      a = 0.004;
      vin[0] = vin0;
      vin[1] = vin1;
      for (int ch = 0; ch < NCH; ch++) v[ch] = 0.5;
      for (int w = 0; w < nwin; w++) begin
         for (int i = 0; i < WIN; i++) begin
            logic [NCH-1:0] bits;
            for (int ch = 0; ch < NCH; ch++) begin
               real fbv;
               fbv = fb_out[ch] ? 1.0 : 0.0;
               v[ch] = v[ch] + a * ((vin[ch] - v[ch]) + (fbv - v[ch]));
               bits[ch] = (v[ch] > 0.5);
            end
            do_tick(bits, 1'b0);
         end
         if (w >= check_from) begin
            for (int ch = 0; ch < NCH; ch++) begin
               int exp_v;
               int act;
               exp_v = $rtoi(vin[ch] * 256.0 + 0.5);
               act = int'(res(ch));
               n_cmp++;
               if (act - exp_v > 2 || exp_v - act > 2) begin
                  n_bad++;
                  $display("FAIL R9 RC tracking ch%0d actual=%0d expected=%0d+-2", ch, act, exp_v);
               end
            end
         end
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog expired actual=running expected=finished");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

   initial begin
      for (int ch = 0; ch < NCH; ch++) last_exp[ch] = '0;
      repeat (4) @(negedge clk);
      for (int ch = 0; ch < NCH; ch++) check("R1 result in reset", res(ch), 0);
      check("R1 fb in reset", fb_out, 0);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1 fb after reset", fb_out, 0);

      drive_window(0, 1'b0, 1'b0, "R5 all-high wraps / R4 zero");
      drive_window(1, 1'b0, 1'b0, "R5 255 ones / R8 alternating");
      drive_window(2, 1'b1, 1'b1, "R7 noise and idle / R3 count");
      drive_window(3, 1'b0, 1'b0, "R4 wrapping tick counted");

      // reset in mid-window
      for (int i = 0; i < 100; i++) do_tick('1, 1'b0);
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      for (int ch = 0; ch < NCH; ch++) begin
         check("R1 result after mid reset", res(ch), 0);
         last_exp[ch] = '0;
      end
      check("R1 fb after mid reset", fb_out, 0);
      rst_n = 1'b1;
      @(negedge clk);
      drive_window(4, 1'b0, 1'b0, "R1 fresh window after reset");

      rc_run(0.25, 0.70, 4, 2);

      repeat (4) @(negedge clk);
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule